// File: doc/BRIEF.md
# Cache Maintenance Range Sequencer

This block takes one cache maintenance request over a byte range given as a start address and an exclusive end address, together with a request kind: invalidate, clean or flush. It turns that request into an ordered stream of commands that a downstream maintenance engine can execute. Each command is either a single-line clean-plus-invalidate or an inclusive line-range clean or invalidate. The sequencer deals with edge lines that are only partly covered by the request. It limits how many bytes a range command may span, and it never lets a range command run across a page boundary.

A write-through override input tells the sequencer that the cache holds no dirty data. When the override is set, clean steps are left out. Commands are handed downstream over a valid/ready handshake. After the last command of a request has been taken, or straight away if a request yields no commands, a one-cycle done pulse marks the end of the request. The block accepts a new request only while it is idle.

Top module: `range_maint_seq`

## Requirements
- R1: After reset, and whenever no request is in progress, req_ready is 1, cmd_valid is 0 and done is 0. A request is taken on a clock edge where req_valid and req_ready are both 1. From that edge until the cycle after its done pulse, req_ready is 0 and req_valid is ignored.
- R2: For an invalidate request (req_op 0) whose start is not a multiple of 32, the first command is a single-line clean-plus-invalidate (cmd_op 1) with cmd_lo = cmd_hi = start rounded down to 32 bytes.
- R3: For an invalidate request whose end is not a multiple of 32, a single-line clean-plus-invalidate (cmd_op 1) at end rounded down to 32 bytes follows the head command. It is left out when R2 has already issued that same line.
- R4: For an invalidate request, after the edge commands, the full lines from start rounded up to end rounded down are invalidated with range commands (cmd_op 3). No range command is issued when that span is empty.
- R5: For clean (req_op 1) and flush (req_op 2) requests, start is rounded down and end is rounded up to 32-byte lines. No single-line commands are issued. The clean ranges use cmd_op 2.
- R6: Every range command has line-aligned bounds with cmd_lo <= cmd_hi, and it covers at most 1024 bytes: cmd_hi - cmd_lo + 32 <= 1024.
- R7: A range command never crosses a 4096-byte page boundary. Each chunk ends at whichever comes first: the span end, cmd_lo + 1024, or the next page boundary. Chunks follow one another in ascending address order with no gaps.
- R8: For a flush request, each chunk is issued as a range clean followed by a range invalidate with identical bounds.
- R9: When wt_override is 1 at the accepting edge, a clean request issues no commands and a flush request issues only the invalidate of each chunk. Changes to wt_override after acceptance have no effect on that request.
- R10: done is high for exactly one cycle. That cycle immediately follows the edge on which the last command was accepted, or immediately follows the accepting edge when the request yields no commands. req_op 3 yields no commands.
- R11: While cmd_valid is 1 and cmd_ready is 0, cmd_valid, cmd_op, cmd_lo and cmd_hi hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no operation |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | Byte just past the range (exclusive) |
| wt_override | input | 1 | Cache is write-through; clean steps are skipped |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_op | output | 2 | 1 line clean+invalidate, 2 range clean, 3 range invalidate |
| cmd_lo | output | ADDR_W | First line address, inclusive |
| cmd_hi | output | ADDR_W | Last line address, inclusive |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The sweep crosses start offsets on both sides of line and page edges with lengths from zero to several pages, for every request kind, both with and without the override. The cases it targets are these:
- Start and end inside one line. A design without the duplicate guard would send that line twice. A design that compares the wrong bounds would run away with range commands.
- Ranges that cross pages. A design that ignores the page limit would emit a command that crosses the boundary.
- Exact 1024-byte spans. An off-by-one in the exclusive-to-inclusive conversion would shift cmd_hi by one line.

Random back-pressure catches commands that change while they wait to be accepted, and done pulses that come early or late. Flipping the override after acceptance exposes a design that samples it live.

// File: rtl/rms_pkg.sv
package rms_pkg;

   typedef enum logic [1:0] {
      RQ_INV   = 2'd0,
      RQ_CLEAN = 2'd1,
      RQ_FLUSH = 2'd2,
      RQ_NONE  = 2'd3
   } rq_op_e;

   typedef enum logic [1:0] {
      CM_NOP       = 2'd0,
      CM_LINE_CI   = 2'd1,
      CM_RNG_CLEAN = 2'd2,
      CM_RNG_INV   = 2'd3
   } cm_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HEAD = 3'd1,
      ST_TAIL = 3'd2,
      ST_RCLN = 3'd3,
      ST_RINV = 3'd4,
      ST_DONE = 3'd5
   } st_e;

endpackage

// File: rtl/rms_bound_prep.sv
// Turns a raw [start, end) request into edge-line work and a line-aligned span.
module rms_bound_prep
   import rms_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] start_a,
   input  logic [ADDR_W-1:0] end_a,
   input  logic              wt,
   output logic              head_pend,
   output logic [ADDR_W-1:0] head_addr,
   output logic              tail_pend,
   output logic [ADDR_W-1:0] tail_addr,
   output logic [ADDR_W-1:0] rng_lo,
   output logic [ADDR_W:0]   rng_lim,
   output logic              do_clean,
   output logic              do_inv,
   output logic              rng_go
);
   localparam int LB = $clog2(LINE_BYTES);
   localparam logic [ADDR_W:0] LINE_X = (ADDR_W+1)'(LINE_BYTES);

   logic [ADDR_W-1:0] s_dn, e_dn;
   logic              s_off, e_off;
   logic [ADDR_W:0]   s_up_x, e_up_x, lo_x;

   assign s_dn   = {start_a[ADDR_W-1:LB], {LB{1'b0}}};
   assign e_dn   = {end_a[ADDR_W-1:LB], {LB{1'b0}}};
   assign s_off  = |start_a[LB-1:0];
   assign e_off  = |end_a[LB-1:0];
   assign s_up_x = {1'b0, s_dn} + (s_off ? LINE_X : '0);
   assign e_up_x = {1'b0, e_dn} + (e_off ? LINE_X : '0);

   always_comb begin
      head_pend = 1'b0;
      tail_pend = 1'b0;
      head_addr = s_dn;
      tail_addr = e_dn;
      lo_x      = {1'b0, s_dn};
      rng_lim   = e_up_x;
      do_clean  = 1'b0;
      do_inv    = 1'b0;
      case (op)
         RQ_INV: begin
            head_pend = s_off;
            tail_pend = e_off && !(s_off && (e_dn == s_dn));
            lo_x      = s_up_x;
            rng_lim   = {1'b0, e_dn};
            do_inv    = 1'b1;
         end
         RQ_CLEAN: begin
            do_clean = !wt;
         end
         RQ_FLUSH: begin
            do_clean = !wt;
            do_inv   = 1'b1;
         end
         default: begin
            do_clean = 1'b0;
            do_inv   = 1'b0;
         end
      endcase
   end

   assign rng_lo = lo_x[ADDR_W-1:0];
   assign rng_go = (do_clean || do_inv) && (lo_x < rng_lim);

endmodule

// File: rtl/rms_chunk_limit.sv
// Exclusive end of the chunk that starts at cur: the nearest of span end,
// size cap and next page boundary.
module rms_chunk_limit #(
   parameter int ADDR_W      = 32,
   parameter int CHUNK_BYTES = 1024,
   parameter int PAGE_BYTES  = 4096
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W:0]   lim,
   output logic [ADDR_W:0]   chunk_end,
   output logic              last
);
   localparam int PG_LG = $clog2(PAGE_BYTES);

   logic [ADDR_W:0] cur_x, page_end, cap;

   assign cur_x    = {1'b0, cur};
   assign page_end = {1'b0, cur[ADDR_W-1:PG_LG], {PG_LG{1'b0}}} + (ADDR_W+1)'(PAGE_BYTES);

   generate
      if (CHUNK_BYTES < PAGE_BYTES) begin : g_two_caps
         logic [ADDR_W:0] size_end;
         assign size_end = cur_x + (ADDR_W+1)'(CHUNK_BYTES);
         assign cap      = (size_end < page_end) ? size_end : page_end;
      end else begin : g_page_cap
         // Distance to the page end never exceeds a page, so the size cap never binds.
         assign cap = page_end;
      end
   endgenerate

   assign chunk_end = (lim < cap) ? lim : cap;
   assign last      = (lim <= cap);

endmodule

// File: rtl/range_maint_seq.sv
module range_maint_seq
   import rms_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 32,
   parameter int CHUNK_BYTES = 1024,
   parameter int PAGE_BYTES  = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   input  logic              wt_override,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_op,
   output logic [ADDR_W-1:0] cmd_lo,
   output logic [ADDR_W-1:0] cmd_hi,
   output logic              done
);
   localparam int LB    = $clog2(LINE_BYTES);
   localparam int PG_LG = $clog2(PAGE_BYTES);
   localparam logic [ADDR_W:0]   LINE_X   = (ADDR_W+1)'(LINE_BYTES);
   localparam logic [ADDR_W-1:0] SPAN_MAX = ADDR_W'(CHUNK_BYTES - LINE_BYTES);

   // Elaboration-time parameter checks
   generate
      if ((1 << LB) != LINE_BYTES || LINE_BYTES < 4) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 4");
      end
      if ((1 << PG_LG) != PAGE_BYTES || PG_LG >= ADDR_W) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two below the address space");
      end
      if (CHUNK_BYTES < LINE_BYTES || (CHUNK_BYTES % LINE_BYTES) != 0) begin : g_bad_chunk
         $error("CHUNK_BYTES must be a whole number of lines");
      end
      if (PAGE_BYTES < LINE_BYTES) begin : g_bad_ratio
         $error("PAGE_BYTES must hold at least one line");
      end
   endgenerate

   // Request preparation
   logic              p_head, p_tail, p_clean, p_inv, p_go;
   logic [ADDR_W-1:0] p_head_a, p_tail_a, p_lo;
   logic [ADDR_W:0]   p_lim;

   rms_bound_prep #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES)
   ) u_prep (
      .op        (req_op),
      .start_a   (req_start),
      .end_a     (req_end),
      .wt        (wt_override),
      .head_pend (p_head),
      .head_addr (p_head_a),
      .tail_pend (p_tail),
      .tail_addr (p_tail_a),
      .rng_lo    (p_lo),
      .rng_lim   (p_lim),
      .do_clean  (p_clean),
      .do_inv    (p_inv),
      .rng_go    (p_go)
   );

   // Sequencer state
   st_e               state_q, state_d;
   logic              tail_q, clean_q, inv_q;
   logic [ADDR_W-1:0] head_a_q, tail_a_q, cur_q;
   logic [ADDR_W:0]   lim_q;
   logic [ADDR_W:0]   chunk_end;
   logic              chunk_last;
   logic              accept, fire, rng_left;

   rms_chunk_limit #(
      .ADDR_W      (ADDR_W),
      .CHUNK_BYTES (CHUNK_BYTES),
      .PAGE_BYTES  (PAGE_BYTES)
   ) u_chunk (
      .cur       (cur_q),
      .lim       (lim_q),
      .chunk_end (chunk_end),
      .last      (chunk_last)
   );

   assign accept   = req_valid && (state_q == ST_IDLE);
   assign fire     = cmd_valid && cmd_ready;
   assign rng_left = (clean_q || inv_q) && ({1'b0, cur_q} < lim_q);

   function automatic st_e range_entry(input logic go, input logic cln);
      if (!go)      return ST_DONE;
      else if (cln) return ST_RCLN;
      else          return ST_RINV;
   endfunction

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (p_head)      state_d = ST_HEAD;
               else if (p_tail) state_d = ST_TAIL;
               else             state_d = range_entry(p_go, p_clean);
            end
         end
         ST_HEAD: begin
            if (fire) begin
               if (tail_q) state_d = ST_TAIL;
               else        state_d = range_entry(rng_left, clean_q);
            end
         end
         ST_TAIL: begin
            if (fire) state_d = range_entry(rng_left, clean_q);
         end
         ST_RCLN: begin
            if (fire) begin
               if (inv_q)           state_d = ST_RINV;
               else if (chunk_last) state_d = ST_DONE;
               else                 state_d = ST_RCLN;
            end
         end
         ST_RINV: begin
            if (fire) begin
               if (chunk_last)   state_d = ST_DONE;
               else if (clean_q) state_d = ST_RCLN;
               else              state_d = ST_RINV;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tail_q   <= 1'b0;
         clean_q  <= 1'b0;
         inv_q    <= 1'b0;
         head_a_q <= '0;
         tail_a_q <= '0;
         cur_q    <= '0;
         lim_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            tail_q   <= p_tail;
            clean_q  <= p_clean;
            inv_q    <= p_inv;
            head_a_q <= p_head_a;
            tail_a_q <= p_tail_a;
            cur_q    <= p_lo;
            lim_q    <= p_lim;
         end else if (fire) begin
            // Move on once the last step of the current chunk is taken.
            if ((state_q == ST_RINV) || (state_q == ST_RCLN && !inv_q)) begin
               cur_q <= chunk_end[ADDR_W-1:0];
            end
         end
      end
   end

   // Command outputs
   logic [ADDR_W:0] rng_hi_x;
   assign rng_hi_x = chunk_end - LINE_X;

   always_comb begin
      cmd_valid = 1'b0;
      cmd_op    = CM_NOP;
      cmd_lo    = cur_q;
      cmd_hi    = rng_hi_x[ADDR_W-1:0];
      case (state_q)
         ST_HEAD: begin
            cmd_valid = 1'b1;
            cmd_op    = CM_LINE_CI;
            cmd_lo    = head_a_q;
            cmd_hi    = head_a_q;
         end
         ST_TAIL: begin
            cmd_valid = 1'b1;
            cmd_op    = CM_LINE_CI;
            cmd_lo    = tail_a_q;
            cmd_hi    = tail_a_q;
         end
         ST_RCLN: begin
            cmd_valid = 1'b1;
            cmd_op    = CM_RNG_CLEAN;
         end
         ST_RINV: begin
            cmd_valid = 1'b1;
            cmd_op    = CM_RNG_INV;
         end
         default: cmd_valid = 1'b0;
      endcase
   end

   assign req_ready = (state_q == ST_IDLE);
   assign done      = (state_q == ST_DONE);

   // Assertions
   p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   p_line_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == CM_LINE_CI |-> cmd_lo == cmd_hi);

   p_chunk_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op[1] |-> (cmd_hi >= cmd_lo) && (cmd_hi - cmd_lo <= SPAN_MAX));

   p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_lo[LB-1:0] == '0) && (cmd_hi[LB-1:0] == '0));

   p_page_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op[1] |-> cmd_lo[ADDR_W-1:PG_LG] == cmd_hi[ADDR_W-1:PG_LG]);

   p_flush_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_op == CM_RNG_CLEAN && inv_q |=>
         cmd_valid && cmd_op == CM_RNG_INV && $stable(cmd_lo) && $stable(cmd_hi));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);

   p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=>
         cmd_valid && $stable(cmd_op) && $stable(cmd_lo) && $stable(cmd_hi));

endmodule

// File: tb/test_range_maint_seq.sv
module test_range_maint_seq;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_start = '0;
   logic [AW-1:0] req_end = '0;
   logic          wt_override = 1'b0;
   logic          cmd_valid;
   logic          cmd_ready = 1'b0;
   logic [1:0]    cmd_op;
   logic [AW-1:0] cmd_lo;
   logic [AW-1:0] cmd_hi;
   logic          done;

   range_maint_seq #(.ADDR_W(AW)) i_range_maint_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_start(req_start), .req_end(req_end), .wt_override(wt_override),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
   );

   always #5 clk = ~clk;

   int    n_checks = 0;
   int    n_errors = 0;
   int    exp_n;
   int    exp_op [64];
   int    exp_lo [64];
   int    exp_hi [64];
   string exp_tag [64];
   logic [7:0] lfsr = 8'hA5;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input int op, input int lo, input int hi, input string tag);
      exp_op[exp_n]  = op;
      exp_lo[exp_n]  = lo;
      exp_hi[exp_n]  = hi;
      exp_tag[exp_n] = tag;
      exp_n++;
   endtask

   // Expected command list computed from the requirements
   task automatic build(input int op, input int s, input int e, input bit wt);
      int lo, lim, sd, ed, ce, pe;
      bit cln, inv;
      exp_n = 0;
      cln = 0; inv = 0; lo = 0; lim = 0;
      sd = s & ~31;
      ed = e & ~31;
      if (op == 0) begin
         if ((s & 31) != 0) push(1, sd, sd, "R2");
         if ((e & 31) != 0 && !((s & 31) != 0 && ed == sd)) push(1, ed, ed, "R3");
         lo  = ((s & 31) != 0) ? sd + 32 : s;
         lim = ed;
         inv = 1;
      end else if (op == 1 || op == 2) begin
         lo  = sd;
         lim = (e + 31) & ~31;
         cln = !wt;
         inv = (op == 2);
      end
      if (cln || inv) begin
         while (lo < lim) begin
            ce = lim;
            if (lo + 1024 < ce) ce = lo + 1024;
            pe = (lo | 4095) + 1;
            if (pe < ce) ce = pe;
            if (cln) push(2, lo, ce - 32, (op == 2) ? "R8" : "R5");
            if (inv) push(3, lo, ce - 32, (op == 2) ? "R8" : "R4");
            lo = ce;
         end
      end
   endtask

   task automatic run_req(input int op, input int s, input int len, input bit wt, input bit noise);
      int got, gap, cyc;
      bit stalled;
      int p_op, p_lo, p_hi;
      build(op, s, s + len, wt);
      @(negedge clk);
      check(req_ready === 1'b1, "R1", "ready before request", req_ready, 1);
      req_op = 2'(op); req_start = AW'(s); req_end = AW'(s + len);
      wt_override = wt; req_valid = 1'b1;
      got = 0; gap = 0; cyc = 0; stalled = 0; p_op = 0; p_lo = 0; p_hi = 0;
      forever begin
         @(negedge clk);
         // Busy-time noise: a request that must be ignored
         req_valid = noise;
         req_op = 2'd1; req_start = AW'(32'h40); req_end = AW'(32'h2000);
         wt_override = !wt;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cmd_ready = lfsr[0] | lfsr[2];
         #1;
         gap++; cyc++;
         if (cyc > 3000) begin
            check(1'b0, "R10", "request hung, commands seen", got, exp_n);
            break;
         end
         if (done) begin
            req_valid = 1'b0;
            check(gap == 1, "R10", "cycles from last accept to done", gap, 1);
            check(got == exp_n, wt ? "R9" : "R10", "command count", got, exp_n);
            break;
         end
         if (stalled) begin
            check(cmd_valid && int'(cmd_op) == p_op && int'(cmd_lo) == p_lo && int'(cmd_hi) == p_hi,
                  "R11", "command changed while stalled", cmd_lo, p_lo);
         end
         stalled = 0;
         if (cmd_valid) begin
            check(req_ready == 1'b0, "R1", "ready while busy", req_ready, 0);
            if (got < exp_n) begin
               check(int'(cmd_op) == exp_op[got], exp_tag[got], "cmd_op", cmd_op, exp_op[got]);
               check(int'(cmd_lo) == exp_lo[got], exp_tag[got], "cmd_lo", cmd_lo, exp_lo[got]);
               check(int'(cmd_hi) == exp_hi[got], exp_tag[got], "cmd_hi", cmd_hi, exp_hi[got]);
               if (cmd_op[1]) begin
                  check(int'(cmd_hi) - int'(cmd_lo) + 32 <= 1024, "R6", "chunk bytes",
                        int'(cmd_hi) - int'(cmd_lo) + 32, 1024);
                  check((cmd_lo >> 12) == (cmd_hi >> 12), "R7", "page of cmd_hi",
                        cmd_hi >> 12, cmd_lo >> 12);
               end
            end else begin
               check(1'b0, wt ? "R9" : "R4", "extra command lo", cmd_lo, -1);
            end
            if (cmd_ready) begin
               got++;
               gap = 0;
            end else begin
               stalled = 1;
               p_op = int'(cmd_op); p_lo = int'(cmd_lo); p_hi = int'(cmd_hi);
            end
         end
      end
      @(negedge clk);
      cmd_ready = 1'b0;
      #1;
      check(done == 1'b0, "R10", "done width", done, 0);
      check(req_ready == 1'b1 && cmd_valid == 1'b0, "R1", "idle after done", req_ready, 1);
   endtask

   int starts [10] = '{0, 8, 31, 32, 992, 1000, 4064, 4090, 8152, 12280};
   int lens   [12] = '{0, 1, 24, 32, 33, 64, 1000, 1024, 1056, 3000, 4100, 9000};

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1", "reset state", req_ready, 1);
      rst_n = 1'b1;
      for (int op = 0; op < 4; op++)
         for (int w = 0; w < 2; w++)
            foreach (starts[i])
               foreach (lens[j])
                  run_req(op, starts[i], lens[j], w[0], ((i + j) % 3) == 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 195000, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule